// File: doc/BRIEF.md
# Serial Conversion-Result Transmitter with Generated Clock

This block is the digital tail of a sampling converter. It takes an 18-bit result word from the converter core and shifts it out on a single data line, most significant bit first. It also drives the serial clock and a framing signal, so the host only listens. A conversion is modelled as a fixed number of system-clock cycles, started by a one-cycle strobe, during which the busy output is high.

Two read timings are available. In the after-conversion timing, the word produced by a conversion is sent as soon as that conversion completes, and busy stays high until the final bit has left. In the during-conversion timing, the frame starts together with the new conversion and carries the word of the previous conversion, and busy drops as soon as the conversion phase ends. A 2-bit select sets the serial clock to the system clock divided by 2, 4, 8 or 16, so that slow hosts can keep up. Two inputs invert the idle level and sense of the serial clock and of the framing signal.

Top module: `serial_result_master`

## Requirements
- R1: While the synchronous reset is high, and on the first cycle after it, busy is low, the data line is low, the framing output equals the frame-invert input (inactive) and the clock output equals the clock-invert input. Reset also clears the stored previous result.
- R2: A start strobe seen at a clock edge while busy is low and no frame is running raises busy at that edge. A strobe seen while busy is high changes neither the busy length nor the frame.
- R3: With the during-conversion timing (mode input 1), busy is high for exactly CONV_CYCLES system cycles.
- R4: With the after-conversion timing (mode input 0), busy is high for CONV_CYCLES + 36·H cycles (H defined in R8), and it falls on the same edge that ends the frame.
- R5: Each frame has exactly 18 rising edges of the uninverted serial clock. The bit presented before the k-th rising edge (k = 1..18) is bit 18−k of the word, so bit 17 comes first.
- R6: With the after-conversion timing, the frame starts on the edge where the conversion ends, CONV_CYCLES cycles after busy rose. It carries the result input as sampled on that edge.
- R7: With the during-conversion timing, the frame starts on the same edge at which busy rises. It carries the result captured at the end of the previous conversion, in either timing. After reset that stored value is all zeros.
- R8: With divider select d, the serial clock low and high phases are each H = 2^d system cycles (periods of 2, 4, 8 or 16 cycles). Each frame starts with a low phase.
- R9: Within a frame, the data line changes only on the edge where the uninverted serial clock falls. The value just before a rising edge therefore equals the value just before the following falling edge.
- R10: When the frame-invert input is 0, the framing output is high for exactly 36·H cycles per frame, from the first bit until the last falling clock edge. When the input is 1, the framing output is low for that span. The clock-invert input flips the serial clock output, including its idle level.
- R11: Outside a frame the data line is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| convStart | input | 1 | One-cycle conversion start strobe |
| resultIn | input | 18 | Result word from the converter core |
| readDuring | input | 1 | 1: send previous word during conversion; 0: send after conversion |
| divSel | input | 2 | Serial clock divider select (2^(d+1)) |
| sclkInv | input | 1 | Invert the serial clock output |
| syncInv | input | 1 | Invert the framing output |
| sclkOut | output | 1 | Generated serial clock |
| sdOut | output | 1 | Serial data, MSB first |
| syncOut | output | 1 | Frame-valid indicator |
| busyOut | output | 1 | Conversion in progress |

## Verification
A corrupted conversion counter appears as a wrong busy width within the first conversion, and in the after-conversion timing it also moves the frame start. A wrong phase or bit counter appears as a wrong clock period or rise count within a single frame. A wrong frame-end decision shows on busy in the after-conversion timing at the very edge where busy should fall. A stale or uncleared previous-result register is only visible one conversion later, as the payload of the next during-conversion frame. The bench therefore chains the two timings and follows a reset with a during-conversion read.

// File: rtl/srm_pkg.sv
package srm_pkg;

  // Strobes from the sequencer to the shift datapath
  typedef struct packed {
    logic loadShift;  // start a frame this edge
    logic usePrev;    // frame payload is the stored previous word
    logic capture;    // conversion ends: store the result input
  } srm_strobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CONV = 2'd1,
    ST_SEND = 2'd2
  } srm_state_t;

endpackage

// File: rtl/srm_ctrl.sv
module srm_ctrl
  import srm_pkg::*;
#(
  parameter int CONV_CYCLES = 300
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        convStart,
  input  logic        readDuring,
  input  logic        frameActive,
  input  logic        frameDone,
  output srm_strobe_t strobe,
  output logic        busy
);

  localparam int CNT_W = $clog2(CONV_CYCLES + 1);

  srm_state_t state;
  logic [CNT_W-1:0] convCnt;
  logic modeDuring;
  logic accept;
  logic convEnd;

  assign accept  = (state == ST_IDLE) && !frameActive && convStart;
  assign convEnd = (state == ST_CONV) && (convCnt == '0);
  assign busy    = (state != ST_IDLE);

  always_comb begin
    strobe.loadShift = (accept && readDuring) || (convEnd && !modeDuring);
    strobe.usePrev   = accept && readDuring;
    strobe.capture   = convEnd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      convCnt    <= '0;
      modeDuring <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            state      <= ST_CONV;
            convCnt    <= CNT_W'(CONV_CYCLES - 1);
            modeDuring <= readDuring;
          end
        end
        ST_CONV: begin
          if (convEnd) begin
            state <= modeDuring ? ST_IDLE : ST_SEND;
          end else begin
            convCnt <= convCnt - 1'b1;
          end
        end
        ST_SEND: begin
          if (frameDone) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(convStart));

  // R4
  after_release_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && !modeDuring) |-> $past(frameDone));

  // R3
  conv_range_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CONV) |-> (convCnt < CNT_W'(CONV_CYCLES)));

  // R2
  send_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SEND) |-> (!modeDuring && frameActive));

endmodule

// File: rtl/srm_datapath.sv
module srm_datapath
  import srm_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int DIV_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  srm_strobe_t       strobe,
  input  logic [DATA_W-1:0] resultIn,
  input  logic [DIV_W-1:0]  divSel,
  input  logic              sclkInv,
  input  logic              syncInv,
  output logic              sclkOut,
  output logic              sdOut,
  output logic              syncOut,
  output logic              frameActive,
  output logic              frameDone
);

  localparam int PH_W  = (1 << DIV_W) - 1;
  localparam int BIT_W = $clog2(DATA_W);

  logic [DATA_W-1:0] prevWord;
  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] loadWord;
  logic [BIT_W-1:0]  bitCnt;
  logic [PH_W-1:0]   phaseCnt;
  logic [PH_W-1:0]   halfLast;
  logic [PH_W:0]     halfFull;
  logic              sclkRaw;
  logic              active;
  logic              phaseEnd;
  logic              lastBit;

  assign loadWord = strobe.usePrev ? prevWord : resultIn;
  assign halfFull = {{PH_W{1'b0}}, 1'b1} << divSel;
  assign phaseEnd = (phaseCnt == halfLast);
  assign lastBit  = (bitCnt == BIT_W'(DATA_W - 1));
  assign frameDone = active && sclkRaw && phaseEnd && lastBit;

  always_ff @(posedge clk) begin
    if (rst) begin
      prevWord <= '0;
    end else if (strobe.capture) begin
      prevWord <= resultIn;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg <= '0;
      bitCnt   <= '0;
      phaseCnt <= '0;
      halfLast <= '0;
      sclkRaw  <= 1'b0;
      active   <= 1'b0;
    end else if (strobe.loadShift) begin
      shiftReg <= loadWord;
      bitCnt   <= '0;
      phaseCnt <= '0;
      halfLast <= PH_W'(halfFull - 1'b1);
      sclkRaw  <= 1'b0;
      active   <= 1'b1;
    end else if (active) begin
      if (phaseEnd) begin
        phaseCnt <= '0;
        if (!sclkRaw) begin
          sclkRaw <= 1'b1;
        end else begin
          sclkRaw <= 1'b0;
          if (lastBit) begin
            active   <= 1'b0;
            shiftReg <= '0;
          end else begin
            shiftReg <= {shiftReg[DATA_W-2:0], 1'b0};
            bitCnt   <= bitCnt + 1'b1;
          end
        end
      end else begin
        phaseCnt <= phaseCnt + 1'b1;
      end
    end
  end

  assign sclkOut     = sclkRaw ^ sclkInv;
  assign syncOut     = active ^ syncInv;
  assign sdOut       = shiftReg[DATA_W-1];
  assign frameActive = active;

  // R11
  idle_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !active |-> (shiftReg == '0 && !sclkRaw));

  // R5
  bit_range_chk: assert property (@(posedge clk) disable iff (rst)
    active |-> (bitCnt < BIT_W'(DATA_W)));

  // R9
  sdout_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (active && $past(active) && (sdOut != $past(sdOut))) |-> $fell(sclkRaw));

  // R8
  phase_range_chk: assert property (@(posedge clk) disable iff (rst)
    active |-> (phaseCnt <= halfLast));

  // R5
  no_reload_chk: assert property (@(posedge clk) disable iff (rst)
    active |-> !strobe.loadShift);

endmodule

// File: rtl/serial_result_master.sv
module serial_result_master
  import srm_pkg::*;
#(
  parameter int DATA_W      = 18,
  parameter int DIV_W       = 2,
  parameter int CONV_CYCLES = 300
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              convStart,
  input  logic [DATA_W-1:0] resultIn,
  input  logic              readDuring,
  input  logic [DIV_W-1:0]  divSel,
  input  logic              sclkInv,
  input  logic              syncInv,
  output logic              sclkOut,
  output logic              sdOut,
  output logic              syncOut,
  output logic              busyOut
);

  srm_strobe_t strobe;
  logic frameActive;
  logic frameDone;

  srm_ctrl #(
    .CONV_CYCLES(CONV_CYCLES)
  ) i_ctrl (
    .clk        (clk),
    .rst        (rst),
    .convStart  (convStart),
    .readDuring (readDuring),
    .frameActive(frameActive),
    .frameDone  (frameDone),
    .strobe     (strobe),
    .busy       (busyOut)
  );

  srm_datapath #(
    .DATA_W(DATA_W),
    .DIV_W (DIV_W)
  ) i_datapath (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .resultIn   (resultIn),
    .divSel     (divSel),
    .sclkInv    (sclkInv),
    .syncInv    (syncInv),
    .sclkOut    (sclkOut),
    .sdOut      (sdOut),
    .syncOut    (syncOut),
    .frameActive(frameActive),
    .frameDone  (frameDone)
  );

endmodule

// File: tb/test_serial_result_master.sv
`timescale 1ns/1ps
module test_serial_result_master;

  localparam int DATA_W = 18;
  localparam int DIV_W = 2;
  localparam int CONV_CYCLES = 300;

  typedef struct packed {
    logic        during;
    logic [1:0]  div;
    logic        sInv;
    logic        yInv;
    logic        extra;
    logic [17:0] data;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 18'h2A5C3},
    '{1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 18'h3FFFF},
    '{1'b1, 2'd1, 1'b1, 1'b0, 1'b0, 18'h00001},
    '{1'b0, 2'd2, 1'b0, 1'b1, 1'b0, 18'h25A5A},
    '{1'b1, 2'd3, 1'b1, 1'b1, 1'b0, 18'h1B3C7},
    '{1'b0, 2'd3, 1'b1, 1'b0, 1'b0, 18'h20000},
    '{1'b1, 2'd2, 1'b0, 1'b0, 1'b1, 18'h0F0F0},
    '{1'b0, 2'd1, 1'b0, 1'b1, 1'b1, 18'h3C3C3}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic convStart = 1'b0;
  logic [DATA_W-1:0] resultIn = '0;
  logic readDuring = 1'b0;
  logic [DIV_W-1:0] divSel = '0;
  logic sclkInv = 1'b0;
  logic syncInv = 1'b0;
  logic sclkOut, sdOut, syncOut, busyOut;

  always #2.5 clk = ~clk;

  serial_result_master #(
    .DATA_W(DATA_W), .DIV_W(DIV_W), .CONV_CYCLES(CONV_CYCLES)
  ) i_serial_result_master (
    .clk(clk), .rst(rst), .convStart(convStart), .resultIn(resultIn),
    .readDuring(readDuring), .divSel(divSel), .sclkInv(sclkInv),
    .syncInv(syncInv), .sclkOut(sclkOut), .sdOut(sdOut),
    .syncOut(syncOut), .busyOut(busyOut)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [17:0] prevExp = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic run_conv(input vec_t v);
    int h, n, busyCnt, syncCnt, syncFirst, rises, runLen;
    int phaseErr, stabErr, idleErr, expBusy, expFirst;
    logic raw, sy, prevRaw, prevSync, prevSd, lastBit, firstBusy;
    logic [17:0] word, expWord;
    h = 1 << v.div;
    expWord = v.during ? prevExp : v.data;
    expBusy = v.during ? CONV_CYCLES : CONV_CYCLES + 36 * h;
    expFirst = v.during ? 1 : CONV_CYCLES + 1;
    n = 0; busyCnt = 0; syncCnt = 0; syncFirst = -1; rises = 0; runLen = 0;
    phaseErr = 0; stabErr = 0; idleErr = 0;
    prevRaw = 1'b0; prevSync = 1'b0; prevSd = 1'b0; lastBit = 1'b0;
    firstBusy = 1'b0; word = '0;
    @(negedge clk);
    readDuring = v.during; divSel = v.div; sclkInv = v.sInv;
    syncInv = v.yInv; resultIn = v.data; convStart = 1'b1;
    @(negedge clk);
    convStart = 1'b0;
    while (1) begin
      n++;
      raw = sclkOut ^ v.sInv;
      sy = syncOut ^ v.yInv;
      if (n == 1) firstBusy = busyOut;
      busyCnt += int'(busyOut);
      if (sy) begin
        syncCnt++;
        if (syncFirst < 0) syncFirst = n;
      end else if (sdOut !== 1'b0) begin
        idleErr++;
      end
      if (sy && !prevSync) begin
        runLen = 1;
        if (raw) phaseErr++;
      end else if (prevSync) begin
        if (!sy || raw != prevRaw) begin
          if (runLen != h) phaseErr++;
          runLen = 1;
        end else begin
          runLen++;
        end
      end
      if (sy && prevSync && raw && !prevRaw) begin
        rises++;
        word = {word[16:0], prevSd};
        lastBit = prevSd;
      end
      if (prevSync && prevRaw && (!raw || !sy) && (prevSd !== lastBit)) stabErr++;
      convStart = (v.extra && n == 5);
      prevRaw = raw; prevSync = sy; prevSd = sdOut;
      if ((!busyOut && !sy) || n > 5000) break;
      @(negedge clk);
    end
    convStart = 1'b0;
    check(firstBusy == 1'b1, "R2", "busy after accepted start", firstBusy, 1);
    if (v.during)
      check(busyCnt == expBusy, "R3", "busy width during-read", busyCnt, expBusy);
    else
      check(busyCnt == expBusy, "R4", "busy width after-read", busyCnt, expBusy);
    if (v.extra)
      check(busyCnt == expBusy && rises == 18, "R2", "strobe while busy ignored", busyCnt, expBusy);
    if (v.during)
      check(syncFirst == expFirst, "R7", "frame start cycle", syncFirst, expFirst);
    else
      check(syncFirst == expFirst, "R6", "frame start cycle", syncFirst, expFirst);
    check(rises == 18, "R5", "rising edges per frame", rises, 18);
    check(word == expWord, v.during ? "R7" : "R6", "frame payload", word, expWord);
    check(syncCnt == 36 * h, "R10", "frame width", syncCnt, 36 * h);
    check(phaseErr == 0, "R8", "clock phase errors", phaseErr, 0);
    check(stabErr == 0, "R9", "data unstable across edges", stabErr, 0);
    check(idleErr == 0, "R11", "data high outside frame", idleErr, 0);
    check(sclkOut == v.sInv && syncOut == v.yInv, "R10", "idle clock/frame levels",
          {sclkOut, syncOut}, {v.sInv, v.yInv});
    prevExp = v.data;
  endtask

  initial begin
    // R1: reset state with both inversions set
    sclkInv = 1'b1; syncInv = 1'b1;
    repeat (4) @(negedge clk);
    check(busyOut == 0 && sdOut == 0, "R1", "busy/data in reset", {busyOut, sdOut}, 0);
    check(syncOut == 1 && sclkOut == 1, "R1", "frame/clock idle in reset", {syncOut, sclkOut}, 3);
    rst = 1'b0;
    @(negedge clk);
    check(busyOut == 0 && sdOut == 0 && syncOut == 1 && sclkOut == 1, "R1",
          "state after reset release", {busyOut, sdOut, syncOut, sclkOut}, 3);

    for (int i = 0; i < NVEC; i++) begin
      run_conv(VECS[i]);
    end

    // R1: reset in the middle of an after-read conversion
    @(negedge clk);
    readDuring = 1'b0; divSel = 2'd0; sclkInv = 1'b0; syncInv = 1'b0;
    resultIn = 18'h3ABCD; convStart = 1'b1;
    @(negedge clk);
    convStart = 1'b0;
    repeat (100) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(busyOut == 0 && sdOut == 0 && syncOut == 0 && sclkOut == 0, "R1",
          "idle after mid-conversion reset", {busyOut, sdOut, syncOut, sclkOut}, 0);
    prevExp = '0;
    // R7: first during-read after reset sends zeros
    run_conv('{1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 18'h155AA});
    // R7: the word captured just now comes out next
    run_conv('{1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 18'h00000});

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule